// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a virtual address into a physical address through a small table of segment descriptors kept inside the block. The top bits of the incoming address pick a descriptor, and the remaining bits form an offset into that segment. Each descriptor carries a start address, a size bound and a present flag.

A legal access returns the descriptor's start address plus the offset. An access to an absent descriptor, or an access whose offset reaches the bound, returns an error with a two-bit cause code and no address. Descriptors are loaded through a write port that accepts only privileged writes. A non-privileged write is discarded and reported.

Lookups use a request strobe. The registered result, marked by a response strobe, appears on the next cycle. The descriptor count, the address width and the width of the segment field are parameters. The default configuration has a 16-bit address, a 2-bit segment field and an eight-entry table. With a 2-bit segment field only entries 0 to 3 can be selected by an address. All eight entries can still be written.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is virtual address bits [ADDR_W-1 : ADDR_W-SEG_W] and the offset is the remaining low bits. In the default configuration these are bits 15:14 and bits 13:0.
- R2: `rspValid` is high in exactly the cycle after a cycle with `reqValid` high, and low in every other cycle.
- R3: When the selected entry is present and the offset is below its bound, the response carries `paddr` = (start + offset) mod 2^ADDR_W, with `errFlag` = 0 and `errCause` = 2'b00.
- R4: When the selected entry is present and the offset is greater than or equal to its bound, the response carries `errFlag` = 1, `errCause` = 2'b10 and `paddr` = 0. Legal offsets therefore run from 0 to bound-1.
- R5: When the selected entry is absent, the response carries `errFlag` = 1, `errCause` = 2'b01 and `paddr` = 0, whatever the offset is.
- R6: Reset marks every entry absent and drives all outputs to 0.
- R7: A write with `wrEn` = 1 and `wrPriv` = 1 stores start, bound and present flag into entry `wrIdx`. Requests in later cycles see the new contents. A request in the same cycle sees the old contents. A privileged write raises no error.
- R8: A write with `wrEn` = 1 and `wrPriv` = 0 leaves the table unchanged, and `wrDenied` is high in the next cycle. If no request is made in the same cycle, that next cycle also shows `errFlag` = 1, `errCause` = 2'b11 and `rspValid` = 0. If a request is made in the same cycle, the lookup result takes the error outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Table write strobe |
| wrPriv | input | 1 | Write issued at privileged level |
| wrIdx | input | 3 | Entry to write |
| wrBase | input | 16 | Segment start address |
| wrLimit | input | 15 | Segment bound (offsets below it are legal) |
| wrValid | input | 1 | Present flag to store |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | 16 | Virtual address to translate |
| rspValid | output | 1 | Lookup result valid |
| paddr | output | 16 | Physical address, 0 on error |
| errFlag | output | 1 | Error present |
| errCause | output | 2 | 00 none, 01 absent, 10 bound, 11 denied write |
| wrDenied | output | 1 | Non-privileged write was discarded |

## Verification
All outputs are registered. The lookup result, the error outputs and the denial pulse all belong to the stimulus applied one clock edge earlier. The bench drives stimulus on the falling edge. On the next falling edge, after exactly one rising edge, it compares every output with a behavioural model of the table. The model computes the expected values from its table contents before it applies that cycle's write. Same-cycle write and lookup therefore check the old-contents rule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'd0,
    CAUSE_ABSENT  = 2'd1,
    CAUSE_BOUND   = 2'd2,
    CAUSE_DENIED  = 2'd3
  } errCause_e;

  typedef struct packed {
    logic tblWr;   // privileged table update
    logic wrDeny;  // discarded user write
    logic xlate;   // lookup this cycle
  } ctrlStrb_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEn,
  input  logic      wrPriv,
  input  logic      reqValid,
  output ctrlStrb_t strb,
  output logic      rspValid,
  output logic      wrDenied
);

  always_comb begin
    strb.tblWr  = wrEn & wrPriv;
    strb.wrDeny = wrEn & ~wrPriv;
    strb.xlate  = reqValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      wrDenied <= 1'b0;
    end else begin
      rspValid <= strb.xlate;
      wrDenied <= strb.wrDeny;
    end
  end

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEG_W   = 2,
  parameter int NUM_ENT = 8,
  localparam int OFF_W  = ADDR_W - SEG_W,
  localparam int LIM_W  = OFF_W + 1,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [LIM_W-1:0]  wrLimit,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic [ADDR_W-1:0] paddr,
  output logic              errFlag,
  output logic [1:0]        errCause
);

  logic [ADDR_W-1:0] entBase  [NUM_ENT];
  logic [LIM_W-1:0]  entLimit [NUM_ENT];
  logic [NUM_ENT-1:0] entValid;

  // descriptor storage, one register set per entry
  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    logic wrHit;
    assign wrHit = strb.tblWr && (wrIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (!rstN) begin
        entBase[i]  <= '0;
        entLimit[i] <= '0;
        entValid[i] <= 1'b0;
      end else if (wrHit) begin
        entBase[i]  <= wrBase;
        entLimit[i] <= wrLimit;
        entValid[i] <= wrValid;
      end
    end
  end

  // lookup path
  logic [SEG_W-1:0]  segNum;
  logic [OFF_W-1:0]  offset;
  logic [IDX_W-1:0]  selIdx;
  logic [ADDR_W-1:0] selBase;
  logic [LIM_W-1:0]  selLimit;
  logic              selValid;
  logic              inBound;
  logic [ADDR_W-1:0] sumAddr;
  errCause_e         lookCause;
  errCause_e         nextCause;
  logic [ADDR_W-1:0] nextPaddr;

  always_comb begin
    segNum   = reqAddr[ADDR_W-1 -: SEG_W];
    offset   = reqAddr[OFF_W-1:0];
    selIdx   = IDX_W'(segNum);
    selBase  = entBase[selIdx];
    selLimit = entLimit[selIdx];
    selValid = entValid[selIdx];
    inBound  = {1'b0, offset} < selLimit;
    sumAddr  = selBase + ADDR_W'(offset);
    if (!selValid)     lookCause = CAUSE_ABSENT;
    else if (!inBound) lookCause = CAUSE_BOUND;
    else               lookCause = CAUSE_NONE;
  end

  always_comb begin
    nextPaddr = '0;
    nextCause = CAUSE_NONE;
    if (strb.xlate) begin
      nextCause = lookCause;
      if (lookCause == CAUSE_NONE) nextPaddr = sumAddr;
    end else if (strb.wrDeny) begin
      nextCause = CAUSE_DENIED;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paddr    <= '0;
      errFlag  <= 1'b0;
      errCause <= 2'd0;
    end else begin
      paddr    <= nextPaddr;
      errFlag  <= (nextCause != CAUSE_NONE);
      errCause <= nextCause;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SEG_W   = 2,
  parameter int NUM_ENT = 8,
  localparam int OFF_W  = ADDR_W - SEG_W,
  localparam int LIM_W  = OFF_W + 1,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrPriv,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [LIM_W-1:0]  wrLimit,
  input  logic              wrValid,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [ADDR_W-1:0] paddr,
  output logic              errFlag,
  output logic [1:0]        errCause,
  output logic              wrDenied
);

  ctrlStrb_t strb;

  seg_xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrPriv   (wrPriv),
    .reqValid (reqValid),
    .strb     (strb),
    .rspValid (rspValid),
    .wrDenied (wrDenied)
  );

  seg_xlate_dp #(
    .ADDR_W  (ADDR_W),
    .SEG_W   (SEG_W),
    .NUM_ENT (NUM_ENT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrIdx    (wrIdx),
    .wrBase   (wrBase),
    .wrLimit  (wrLimit),
    .wrValid  (wrValid),
    .reqAddr  (reqAddr),
    .paddr    (paddr),
    .errFlag  (errFlag),
    .errCause (errCause)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              wrPriv,
  input logic              reqValid,
  input logic              rspValid,
  input logic [ADDR_W-1:0] paddr,
  input logic              errFlag,
  input logic [1:0]        errCause,
  input logic              wrDenied
);

  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R2
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R2
  AST_ERR_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (paddr == '0)); // R4
  AST_DENY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrPriv) |=> wrDenied); // R8
  AST_DENIED_NO_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (errCause == 2'd3) |-> !rspValid); // R8
  AST_PRIV_WR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrPriv && !reqValid) |=> (!errFlag && !wrDenied)); // R7

endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .wrEn     (wrEn),
  .wrPriv   (wrPriv),
  .reqValid (reqValid),
  .rspValid (rspValid),
  .paddr    (paddr),
  .errFlag  (errFlag),
  .errCause (errCause),
  .wrDenied (wrDenied)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;

  localparam int CLK_P   = 10;
  localparam int ADDR_W  = 16;
  localparam int SEG_W   = 2;
  localparam int NUM_ENT = 8;
  localparam int OFF_W   = ADDR_W - SEG_W;
  localparam int LIM_W   = OFF_W + 1;
  localparam int IDX_W   = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic              wrPriv = 1'b0;
  logic [IDX_W-1:0]  wrIdx = '0;
  logic [ADDR_W-1:0] wrBase = '0;
  logic [LIM_W-1:0]  wrLimit = '0;
  logic              wrValid = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              rspValid;
  logic [ADDR_W-1:0] paddr;
  logic              errFlag;
  logic [1:0]        errCause;
  logic              wrDenied;

  seg_xlate u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrPriv(wrPriv), .wrIdx(wrIdx),
    .wrBase(wrBase), .wrLimit(wrLimit), .wrValid(wrValid),
    .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
    .paddr(paddr), .errFlag(errFlag), .errCause(errCause), .wrDenied(wrDenied)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // behavioural model of the table
  int mBase [NUM_ENT];
  int mLim  [NUM_ENT];
  bit mVld  [NUM_ENT];

  int    expRsp = 0, expPaddr = 0, expFlag = 0, expCause = 0, expDen = 0;
  string prevTag = "R6";

  task automatic compare();
    checks++;
    if (rspValid !== expRsp[0] || paddr !== expPaddr[ADDR_W-1:0] ||
        errFlag !== expFlag[0] || errCause !== expCause[1:0] || wrDenied !== expDen[0]) begin
      failures++;
      $display("FAIL %s: got rsp=%0d paddr=%h flag=%0d cause=%0d den=%0d expected rsp=%0d paddr=%h flag=%0d cause=%0d den=%0d",
               prevTag, rspValid, paddr, errFlag, errCause, wrDenied,
               expRsp, expPaddr, expFlag, expCause, expDen);
    end
  endtask

  task automatic step(input string tag, input bit we, input bit wp, input int idx,
                      input int b, input int l, input bit v, input bit rq, input int a);
    int seg, off;
    @(negedge clk);
    compare();
    wrEn = we; wrPriv = wp; wrIdx = IDX_W'(idx); wrBase = ADDR_W'(b);
    wrLimit = LIM_W'(l); wrValid = v; reqValid = rq; reqAddr = ADDR_W'(a);
    expRsp = rq; expPaddr = 0; expCause = 0;
    expDen = (we && !wp) ? 1 : 0;
    if (rq) begin
      seg = (a >> OFF_W) & ((1 << SEG_W) - 1);
      off = a & ((1 << OFF_W) - 1);
      if (!mVld[seg]) expCause = 1;
      else if (off >= mLim[seg]) expCause = 2;
      else expPaddr = (mBase[seg] + off) & ((1 << ADDR_W) - 1);
    end else if (we && !wp) begin
      expCause = 3;
    end
    expFlag = (expCause != 0) ? 1 : 0;
    if (we && wp) begin
      mBase[idx] = b; mLim[idx] = l; mVld[idx] = v;
    end
    prevTag = tag;
  endtask

  task automatic load(input string tag, input int idx, input int b, input int l, input bit v);
    step(tag, 1, 1, idx, b, l, v, 0, 0);
  endtask

  task automatic look(input string tag, input int a);
    step(tag, 0, 0, 0, 0, 0, 0, 1, a);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_ENT; i++) begin mBase[i] = 0; mLim[i] = 0; mVld[i] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R6: outputs zero after reset, every entry absent
    idle("R6");
    look("R6", 16'h0000);
    look("R6", 16'hC010);
    // R8: user write discarded and reported, entry stays absent
    step("R8", 1, 0, 0, 16'h4000, 16'h0800, 1, 0, 0);
    look("R8", 16'h0010);
    // R7: privileged loads of the test configuration
    load("R7", 0, 16'h4000, 16'h0800, 1);
    load("R7", 1, 16'h4800, 16'h1400, 1);
    load("R7", 2, 16'hF000, 16'h1000, 1);
    // R7: load of segment 3 together with a lookup of it sees old (absent) contents
    step("R7", 1, 1, 3, 16'h0000, 16'h3000, 1, 1, 16'hC005);
    load("R7", 5, 16'h1234, 16'h0100, 1);
    // R3 / R1: legal translations
    look("R3", 16'h0123);
    look("R3", 16'h07FF);
    look("R1", 16'h53FF);
    look("R3", 16'h8FFF);
    look("R1", 16'hEFFF);
    look("R3", 16'hC000);
    // R4: bound equal and above
    look("R4", 16'h0800);
    look("R4", 16'h5400);
    look("R4", 16'h9000);
    look("R1", 16'hBFFF);
    look("R4", 16'hF000);
    // R2: idle cycle between requests
    idle("R2");
    look("R2", 16'h4000);
    idle("R2");
    // R8: user write with concurrent lookup, table unchanged
    step("R8", 1, 0, 1, 16'h0000, 16'h0001, 0, 1, 16'h4100);
    look("R8", 16'h4100);
    // R5: entry made absent, lookup in and out of bound
    load("R5", 2, 16'hF000, 16'h1000, 0);
    look("R5", 16'h8000);
    look("R5", 16'hBFFF);
    // R3: wrap-around of start plus offset
    load("R3", 0, 16'hFFFF, 16'h0010, 1);
    look("R3", 16'h0002);
    look("R4", 16'h0010);
    idle("R2");
    idle("R2");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule